// File: doc/BRIEF.md
# Per-Line Programmable Edge Detector Bank

The block watches a wide bank of single-bit input lines, up to 256 of them. For each line it raises a one-cycle event when that line makes the kind of transition that software picked for it. The choices are a low-to-high change, a high-to-low change, or any change. A separate per-line mask bit can block the event for that line.

Software sets the block up through a simple register port with write and read strobes. The port holds packed edge-selection words, sixteen lines to a 32-bit word, and packed mask words, thirty-two lines to a word. Every word can be read back. Setting the enable bit copies the programmed words into the detector and starts it comparing each new sample of the lines with the one before.

While the block is enabled, writes to the configuration words change only the readback copy. They take effect at the next enable. `NUM_LINES` must be a multiple of 32, between 32 and 256.

Top module: `edge_detect_bank`

## Requirements
- R1: After reset, every configuration word and the control register read 0, the enable bit is 0, and `events` is all zero.
- R2: The control register is at byte address 0x780 and its bit 0 is the enable. Edge-selection word n is at 0x808 + 4n and mask word n is at 0x848 + 4n. Read data appears on `rdData` one cycle after `rdEn`. Reads of any other address, including a misaligned one, return 0, and writes to such an address change no word.
- R3: Line r takes its 2-bit selection code from bits (r mod 16)*2+1 and (r mod 16)*2 of edge-selection word r/16. It takes its mask from bit r mod 32 of mask word r/32.
- R4: Code 00 gives an event on a 0-to-1 change of the line.
- R5: Code 01 gives an event on a 1-to-0 change of the line.
- R6: Code 10 gives an event on any change of the line.
- R7: Code 11 never gives an event.
- R8: A line whose mask bit is 1 never gives an event. A mask bit of 0 lets the selected detection through.
- R9: An event is high for exactly one cycle. It appears in the cycle after the clock edge that first samples the changed value. A line that holds steady gives no event.
- R10: When enable goes from 0 to 1, the previous-sample register takes the current line values, so no event appears for a difference from the lines before enable.
- R11: The detector uses the configuration that was held when enable went from 0 to 1. Writes made while enabled show in readback and take effect only at the next 0-to-1 enable.
- R12: While the enable bit is 0, `events` stays all zero whatever the lines do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered one cycle after `rdEn` |
| lines | input | NUM_LINES | Monitored lines |
| events | output | NUM_LINES | One-cycle event per line |

## Verification
The hardest situation to reach from the ports is a mismatch between the live detector configuration and the configuration that software reads back. This mismatch exists only after words are rewritten while the block is enabled. The stimulus creates it by changing the code of a falling-edge line to rising while the block is enabled. It then shows that the old falling behaviour persists, disables and re-enables the block, and shows that the new rising behaviour takes over. A second case that needs care is the first cycle after enable. The lines are driven high while the block is disabled, so that a rising-edge line would fire falsely if the previous sample were not reloaded at enable.

// File: rtl/edb_pkg.sv
package edb_pkg;

  localparam logic [11:0] CTRL_ADDR = 12'h780;
  localparam logic [11:0] CW_BASE   = 12'h808;
  localparam logic [11:0] MW_BASE   = 12'h848;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edgeSel_e;

  typedef struct packed {
    logic load;
    logic halt;
  } edbStrobe_t;

endpackage

// File: rtl/edb_line_cell.sv
module edb_line_cell (
  input  logic       prevBit,
  input  logic       curBit,
  input  logic [1:0] code,
  input  logic       maskBit,
  output logic       hit
);
  import edb_pkg::*;

  logic rise;
  logic fall;
  logic raw;

  assign rise = ~prevBit & curBit;
  assign fall = prevBit & ~curBit;

  always_comb begin
    case (edgeSel_e'(code))
      EDGE_RISE: raw = rise;
      EDGE_FALL: raw = fall;
      EDGE_BOTH: raw = rise | fall;
      default:   raw = 1'b0;
    endcase
  end

  assign hit = raw & ~maskBit;
endmodule

// File: rtl/edb_regs.sv
module edb_regs #(
  parameter int NUM_LINES = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [11:0]            regAddr,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  output edb_pkg::edbStrobe_t    strobe,
  output logic                   enableBit,
  output logic [2*NUM_LINES-1:0] cfgCode,
  output logic [NUM_LINES-1:0]   cfgMask
);
  import edb_pkg::*;

  localparam int NUM_CW = NUM_LINES / 16;
  localparam int NUM_MW = NUM_LINES / 32;
  localparam int CW_IW  = (NUM_CW > 1) ? $clog2(NUM_CW) : 1;
  localparam int MW_IW  = (NUM_MW > 1) ? $clog2(NUM_MW) : 1;
  localparam logic [9:0] CW_LIM = 10'(NUM_CW);
  localparam logic [9:0] MW_LIM = 10'(NUM_MW);

  logic [11:0] cwOff;
  logic [11:0] mwOff;
  logic        isCtrl;
  logic        cwHit;
  logic        mwHit;
  logic [CW_IW-1:0] cwIdx;
  logic [MW_IW-1:0] mwIdx;
  logic [31:0] rdNext;
  logic [NUM_CW*32-1:0] cwFlat;
  logic [NUM_MW*32-1:0] mwFlat;

  assign cwOff  = regAddr - CW_BASE;
  assign mwOff  = regAddr - MW_BASE;
  assign isCtrl = (regAddr == CTRL_ADDR);
  assign cwHit  = (regAddr >= CW_BASE) && (regAddr[1:0] == 2'b00) && (cwOff[11:2] < CW_LIM);
  assign mwHit  = (regAddr >= MW_BASE) && (regAddr[1:0] == 2'b00) && (mwOff[11:2] < MW_LIM);
  assign cwIdx  = cwOff[2 +: CW_IW];
  assign mwIdx  = mwOff[2 +: MW_IW];

  for (genvar n = 0; n < NUM_CW; n++) begin : g_cw
    logic [31:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        word <= '0;
      else if (wrEn && cwHit && (cwIdx == CW_IW'(n)))   word <= wrData;
    end
    assign cwFlat[n*32 +: 32] = word;
  end

  for (genvar n = 0; n < NUM_MW; n++) begin : g_mw
    logic [31:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                        word <= '0;
      else if (wrEn && mwHit && (mwIdx == MW_IW'(n)))   word <= wrData;
    end
    assign mwFlat[n*32 +: 32] = word;
  end

  assign cfgCode = cwFlat;
  assign cfgMask = mwFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               enableBit <= 1'b0;
    else if (wrEn && isCtrl) enableBit <= wrData[0];
  end

  // a 0->1 change of enable loads the detector, a 0 write stops it
  assign strobe.load = wrEn && isCtrl && wrData[0] && !enableBit;
  assign strobe.halt = wrEn && isCtrl && !wrData[0];

  always_comb begin
    rdNext = '0;
    if (isCtrl)     rdNext = {31'b0, enableBit};
    else if (cwHit) rdNext = cwFlat[{cwIdx, 5'b0} +: 32];
    else if (mwHit) rdNext = mwFlat[{mwIdx, 5'b0} +: 32];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rdData <= '0;
    else if (rdEn)  rdData <= rdNext;
  end
endmodule

// File: rtl/edb_detect.sv
module edb_detect #(
  parameter int NUM_LINES = 256
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  edb_pkg::edbStrobe_t    strobe,
  input  logic [2*NUM_LINES-1:0] cfgCode,
  input  logic [NUM_LINES-1:0]   cfgMask,
  input  logic [NUM_LINES-1:0]   lines,
  output logic [NUM_LINES-1:0]   events,
  output logic                   running
);
  logic [2*NUM_LINES-1:0] actCode;
  logic [NUM_LINES-1:0]   actMask;
  logic [NUM_LINES-1:0]   prevLines;
  logic [NUM_LINES-1:0]   hitVec;

  for (genvar r = 0; r < NUM_LINES; r++) begin : g_line
    edb_line_cell u_cell (
      .prevBit (prevLines[r]),
      .curBit  (lines[r]),
      .code    (actCode[2*r +: 2]),
      .maskBit (actMask[r]),
      .hit     (hitVec[r])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCode   <= '0;
      actMask   <= '0;
      prevLines <= '0;
      running   <= 1'b0;
      events    <= '0;
    end else if (strobe.load) begin
      actCode   <= cfgCode;
      actMask   <= cfgMask;
      prevLines <= lines;
      running   <= 1'b1;
      events    <= '0;
    end else if (strobe.halt) begin
      running   <= 1'b0;
      events    <= '0;
    end else if (running) begin
      prevLines <= lines;
      events    <= hitVec;
    end else begin
      events    <= '0;
    end
  end
endmodule

// File: rtl/edge_detect_bank.sv
module edge_detect_bank #(
  parameter int NUM_LINES = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [11:0]          regAddr,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  input  logic [NUM_LINES-1:0] lines,
  output logic [NUM_LINES-1:0] events
);
  edb_pkg::edbStrobe_t    strobe;
  logic                   enableBit;
  logic                   running;
  logic [2*NUM_LINES-1:0] cfgCode;
  logic [NUM_LINES-1:0]   cfgMask;

  edb_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .regAddr   (regAddr),
    .wrData    (wrData),
    .rdData    (rdData),
    .strobe    (strobe),
    .enableBit (enableBit),
    .cfgCode   (cfgCode),
    .cfgMask   (cfgMask)
  );

  edb_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgCode (cfgCode),
    .cfgMask (cfgMask),
    .lines   (lines),
    .events  (events),
    .running (running)
  );
endmodule

// File: rtl/edb_checker.sv
module edb_checker #(
  parameter int NUM_LINES = 256
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [11:0]          regAddr,
  input logic [31:0]          wrData,
  input logic [NUM_LINES-1:0] lines,
  input logic [NUM_LINES-1:0] events,
  input logic                 running,
  input logic                 enableBit,
  input logic                 loadStb
);
  a_r12_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (events == '0));

  a_r10_no_first_event: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> (events == '0));

  a_r9_event_needs_change: assert property (@(posedge clk) disable iff (!rstN)
    (events & ~($past(lines) ^ $past(lines, 2))) == '0);

  a_r2_enable_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && (regAddr == edb_pkg::CTRL_ADDR)) |-> (enableBit == $past(wrData[0])));

  a_r11_load_on_rise_only: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> !enableBit);

  a_r11_run_matches_enable: assert property (@(posedge clk) disable iff (!rstN)
    running == enableBit);
endmodule

bind edge_detect_bank edb_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .regAddr   (regAddr),
  .wrData    (wrData),
  .lines     (lines),
  .events    (events),
  .running   (running),
  .enableBit (enableBit),
  .loadStb   (strobe.load)
);

// File: tb/test_edge_detect_bank.sv
module test_edge_detect_bank;
  localparam int NL = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [11:0]   regAddr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NL-1:0] lines = '0;
  logic [NL-1:0] events;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [1:0] shCode  [NL];
  logic       shMask  [NL];
  logic [1:0] actCode [NL];
  logic       actMask [NL];
  logic [NL-1:0] prevB = '0;
  logic [NL-1:0] expV;
  logic [31:0]   rd;

  edge_detect_bank #(.NUM_LINES(NL)) i_edge_detect_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .lines(lines), .events(events)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] model(input logic [NL-1:0] p, input logic [NL-1:0] c);
    logic [NL-1:0] e;
    for (int r = 0; r < NL; r++) begin
      case (actCode[r])
        2'b00:   e[r] = ~p[r] & c[r];
        2'b01:   e[r] = p[r] & ~c[r];
        2'b10:   e[r] = p[r] ^ c[r];
        default: e[r] = 1'b0;
      endcase
      if (actMask[r]) e[r] = 1'b0;
    end
    return e;
  endfunction

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; regAddr = a;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic writeCodeWord(input int n);
    logic [31:0] w;
    for (int k = 0; k < 16; k++) w[k*2 +: 2] = shCode[n*16 + k];
    regWrite(12'(32'h808 + 4*n), w);
  endtask

  task automatic writeMaskWord(input int n);
    logic [31:0] w;
    for (int k = 0; k < 32; k++) w[k] = shMask[n*32 + k];
    regWrite(12'(32'h848 + 4*n), w);
  endtask

  // drive new lines, then sample events one edge later
  task automatic setLines(input logic [NL-1:0] v);
    @(negedge clk); lines = v;
    expV  = model(prevB, v);
    prevB = v;
    @(negedge clk);
  endtask

  task automatic enableOn();
    regWrite(12'h780, 32'h1);
    for (int r = 0; r < NL; r++) begin actCode[r] = shCode[r]; actMask[r] = shMask[r]; end
    prevB = lines;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 events after reset", events, '0);
    regRead(12'h780, rd); chk("R1 control reg", NL'(rd), '0);
    regRead(12'h808, rd); chk("R1 code word 0", NL'(rd), '0);
    regRead(12'h844, rd); chk("R1 code word 15", NL'(rd), '0);
    regRead(12'h848, rd); chk("R1 mask word 0", NL'(rd), '0);
  endtask

  task automatic t_config();
    for (int r = 0; r < NL; r++) begin shCode[r] = 2'b00; shMask[r] = 1'b0; end
    shCode[1] = 2'b01; shCode[2] = 2'b10; shCode[3] = 2'b11;
    shCode[17] = 2'b01; shCode[40] = 2'b10; shCode[41] = 2'b10; shCode[255] = 2'b10;
    shMask[40] = 1'b1;
    writeCodeWord(0); writeCodeWord(1); writeCodeWord(2); writeCodeWord(15);
    writeMaskWord(1);
    regRead(12'h808, rd); chk("R3 code word 0 packing", NL'(rd), NL'(32'h0000_00E4));
    regRead(12'h80C, rd); chk("R3 code word 1 packing", NL'(rd), NL'(32'h0000_0004));
    regRead(12'h810, rd); chk("R3 code word 2 packing", NL'(rd), NL'(32'h000A_0000));
    regRead(12'h844, rd); chk("R2 code word 15 readback", NL'(rd), NL'(32'h8000_0000));
    regRead(12'h84C, rd); chk("R3 mask word 1 packing", NL'(rd), NL'(32'h0000_0100));
    regRead(12'h848, rd); chk("R2 mask word 0 readback", NL'(rd), '0);
  endtask

  task automatic t_enable_no_false();
    @(negedge clk); lines = '1;
    @(negedge clk); chk("R12 disabled lines rise", events, '0);
    enableOn();
    chk("R10 first cycle after enable", events, '0);
    @(negedge clk); chk("R10 second cycle after enable", events, '0);
  endtask

  task automatic t_edges();
    logic [NL-1:0] ev;
    setLines('0);
    ev = events;
    chk("R9 all-fall vector", ev, expV);
    chk("R4 rise line ignores fall", NL'(ev[0]), '0);
    chk("R5 fall line fires", NL'(ev[1]), NL'(1));
    chk("R6 toggle line fires on fall", NL'(ev[2]), NL'(1));
    chk("R7 reserved code silent", NL'(ev[3]), '0);
    chk("R8 masked line silent", NL'(ev[40]), '0);
    chk("R3 line 255 toggle", NL'(ev[255]), NL'(1));
    @(negedge clk); chk("R9 pulse lasts one cycle", events, '0);
    setLines('1);
    ev = events;
    chk("R9 all-rise vector", ev, expV);
    chk("R4 rise line fires", NL'(ev[0]), NL'(1));
    chk("R5 fall line ignores rise", NL'(ev[1]), '0);
    chk("R6 toggle line fires on rise", NL'(ev[2]), NL'(1));
    chk("R8 masked line silent on rise", NL'(ev[40]), '0);
    setLines(~(NL'(1) << 17));
    chk("R5 single line 17 fall", events, NL'(1) << 17);
    setLines('1);
    chk("R4 line 17 rise with fall code", events, '0);
  endtask

  task automatic t_live_write();
    shCode[1] = 2'b00; shCode[2] = 2'b00; shCode[3] = 2'b00;
    writeCodeWord(0);
    regRead(12'h808, rd); chk("R11 readback shows new word", NL'(rd), '0);
    setLines('0);
    chk("R11 old config still active", NL'(events[1]), NL'(1));
    chk("R11 old config vector", events, expV);
    setLines('1);
    regWrite(12'h780, 32'h0);
    setLines('0);
    chk("R12 disabled fall", events, '0);
    setLines('1);
    chk("R12 disabled rise", events, '0);
    regRead(12'h780, rd); chk("R2 enable reads 0", NL'(rd), '0);
    enableOn();
    regRead(12'h780, rd); chk("R2 enable reads 1", NL'(rd), NL'(1));
    setLines('0);
    chk("R11 new rise code on fall", NL'(events[1]), '0);
    chk("R11 reconfigured vector fall", events, expV);
    setLines('1);
    chk("R11 new rise code fires", NL'(events[1]), NL'(1));
    chk("R7 line 3 now rise fires", NL'(events[3]), NL'(1));
    chk("R11 reconfigured vector rise", events, expV);
  endtask

  task automatic t_unmapped();
    regWrite(12'h900, 32'hFFFF_FFFF);
    regRead(12'h900, rd); chk("R2 unmapped read", NL'(rd), '0);
    regWrite(12'h809, 32'hFFFF_FFFF);
    regRead(12'h808, rd); chk("R2 misaligned write ignored", NL'(rd), '0);
    regRead(12'h804, rd); chk("R2 gap read", NL'(rd), '0);
    regRead(12'h868, rd); chk("R2 beyond mask words", NL'(rd), '0);
    regRead(12'h84C, rd); chk("R2 mask word 1 kept", NL'(rd), NL'(32'h0000_0100));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_config();
    t_enable_no_false();
    t_edges();
    t_live_write();
    t_unmapped();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule